// File: doc/BRIEF.md
# DMA Channel Arm and Abort Control Register

This block holds the arm state of a set of DMA channels behind an 8-bit control register. Software writes the register over a plain bus made of a write enable, write data and read data. The low bits form an arm vector that goes to the channel engines. A channel may only move data while its arm bit is 1. The top bit of a written value turns that write into an abort command. The low bits of the same word then choose which channels are aborted. Aborted channels get a one-cycle abort pulse, and their arm bits are cleared rather than loaded.

Each channel engine returns a completion pulse together with a flag that says whether the channel runs in repetitive mode. A completion without that flag disarms the channel in hardware. A completion with the flag leaves the channel armed. If a software write and a completion hit the same arm bit in the same cycle, the software write decides the result.

Reset is asynchronous and active low. Inside the block it is released in step with the clock, so the register leaves reset two clock edges after the reset input rises.

Top module: `dmaarm_ctrl`

## Requirements
- R1: While reset is active, and on release from reset, the arm vector, the abort pulses and the read data are all 0.
- R2: The read data carries the arm vector in bits 4:0. Bits 7:5 always read 0, even after they were written with 1 (bit 7, the abort bit, included).
- R3: A write whose bit 7 is 0 loads written bits 4:0 as the new arm vector, visible on the clock edge that takes the write. Bit i of the data arms channel i. Bits 6:5 have no effect.
- R4: A write whose bit 7 is 1 clears the arm bit of every channel whose data bit (4:0) is 1. Channels whose data bit is 0 keep their arm state.
- R5: An abort write raises the abort output of each selected channel for exactly the one cycle after the write edge. No abort output rises for any other write or cycle.
- R6: A completion pulse with the repetitive flag at 0 clears that channel's arm bit on the next edge.
- R7: A completion pulse with the repetitive flag at 1 leaves that channel's arm bit set.
- R8: When a normal write (bit 7 at 0) and a completion arrive together, the channel takes the written value. An abort write only overrides completions on the channels it selects, so an unselected channel is still auto-cleared.
- R9: An arm bit only goes from 0 to 1 through a write with bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| chan_done | input | 5 | Per-channel transfer completion pulse |
| chan_done_rep | input | 5 | Per-channel repetitive-mode flag sampled with the completion |
| chan_armed | output | 5 | Per-channel arm state |
| chan_abort | output | 5 | Per-channel one-cycle abort pulse |

## Verification
The bench builds the block with its default parameters: five channels, an 8-bit register and the abort command in bit 7. This setting leaves two unused bits, 6 and 5, between the arm field and the abort bit. So the bench can write ones there and show that they never come back on a read. The five channels let a single write mix selected and unselected channels. A single cycle can also combine repetitive and non-repetitive completions, which brings the collisions of R8 within reach.

// File: rtl/dmaarm_pkg.sv
package dmaarm_pkg;
  localparam int unsigned CH_N      = 5;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ABORT_POS = 7;
endpackage

// File: rtl/dmaarm_rst_sync.sv
module dmaarm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dmaarm_cmd_decode.sv
module dmaarm_cmd_decode #(
  parameter int unsigned NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           abort_flag,
  input  logic [NCH-1:0] chan_field,
  output logic [NCH-1:0] load_en,
  output logic [NCH-1:0] load_val,
  output logic [NCH-1:0] abort_sel
);
  logic is_abort;
  logic is_load;

  always_comb begin
    is_abort = we && abort_flag;
    is_load  = we && !abort_flag;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    always_comb begin
      load_en[g]   = is_load;
      load_val[g]  = chan_field[g];
      abort_sel[g] = is_abort && chan_field[g];
    end
  end

  AST_LOAD_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((|load_en) && (|abort_sel))); // R4
endmodule

// File: rtl/dmaarm_chan_cell.sv
module dmaarm_chan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_val,
  input  logic abort_sel,
  input  logic done,
  input  logic done_rep,
  output logic armed,
  output logic abort_pulse
);
  logic arm_q;
  logic arm_d;
  logic arm_en;
  logic abort_q;
  logic abort_d;
  logic auto_clr;

  always_comb begin
    auto_clr = done && !done_rep;
    arm_en   = load_en || abort_sel || auto_clr;
    arm_d    = arm_q;
    if (load_en) begin
      arm_d = load_val;
    end else if (abort_sel) begin
      arm_d = 1'b0;
    end else if (auto_clr) begin
      arm_d = 1'b0;
    end
    abort_d = abort_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (arm_en) begin
        arm_q <= arm_d;
      end
      abort_q <= abort_d;
    end
  end

  assign armed       = arm_q;
  assign abort_pulse = abort_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (armed == $past(load_val))); // R3
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_sel |=> !armed); // R4
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_sel |=> abort_pulse); // R5
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_sel |=> !abort_pulse); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_rep && !load_en) |=> !armed); // R6
  AST_REP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && done && done_rep && !load_en && !abort_sel) |=> armed); // R7
  AST_NO_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> !$rose(armed)); // R9
endmodule

// File: rtl/dmaarm_ctrl.sv
module dmaarm_ctrl #(
  parameter int unsigned NCH       = dmaarm_pkg::CH_N,
  parameter int unsigned REG_W     = dmaarm_pkg::REG_W,
  parameter int unsigned ABORT_POS = dmaarm_pkg::ABORT_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   chan_done,
  input  logic [NCH-1:0]   chan_done_rep,
  output logic [NCH-1:0]   chan_armed,
  output logic [NCH-1:0]   chan_abort
);
  localparam int unsigned PAD_W = REG_W - NCH;

  logic           rst_n_s;
  logic [NCH-1:0] load_en;
  logic [NCH-1:0] load_val;
  logic [NCH-1:0] abort_sel;

  dmaarm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dmaarm_cmd_decode #(.NCH(NCH)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we         (reg_we),
    .abort_flag (reg_wdata[ABORT_POS]),
    .chan_field (reg_wdata[NCH-1:0]),
    .load_en    (load_en),
    .load_val   (load_val),
    .abort_sel  (abort_sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmaarm_chan_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .load_en     (load_en[g]),
      .load_val    (load_val[g]),
      .abort_sel   (abort_sel[g]),
      .done        (chan_done[g]),
      .done_rep    (chan_done_rep[g]),
      .armed       (chan_armed[g]),
      .abort_pulse (chan_abort[g])
    );
  end

  assign reg_rdata = {{PAD_W{1'b0}}, chan_armed};

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> (chan_armed == '0 && chan_abort == '0)); // R1
  AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && (reg_wdata[REG_W-1:NCH] != '0)) |=> (reg_rdata[REG_W-1:NCH] == '0)); // R2
  AST_RD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_rdata[NCH-1:0] == chan_armed); // R2
endmodule

// File: tb/sim_dmaarm_ctrl.sv
module sim_dmaarm_ctrl;
  localparam int NCH = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic [NCH-1:0] chan_done = '0;
  logic [NCH-1:0] chan_done_rep = '0;
  logic [NCH-1:0] chan_armed;
  logic [NCH-1:0] chan_abort;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_arm [NCH];
  bit exp_ab  [NCH];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmaarm_ctrl u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .chan_done     (chan_done),
    .chan_done_rep (chan_done_rep),
    .chan_armed    (chan_armed),
    .chan_abort    (chan_abort)
  );

  function automatic logic [7:0] pack_arm();
    logic [7:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i] = exp_arm[i];
    return v;
  endfunction

  function automatic logic [NCH-1:0] pack_ab();
    logic [NCH-1:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i] = exp_ab[i];
    return v;
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (reg_rdata !== pack_arm() || chan_armed !== pack_arm()[NCH-1:0] ||
        chan_abort !== pack_ab()) begin
      n_bad++;
      $display("FAIL %s: rdata=%h armed=%b abort=%b expected rdata=%h armed=%b abort=%b",
               tag, reg_rdata, chan_armed, chan_abort, pack_arm(),
               pack_arm()[NCH-1:0], pack_ab());
    end
  endtask

  task automatic step(input bit we, input logic [7:0] wd, input logic [NCH-1:0] dn,
                      input logic [NCH-1:0] rp, input string tag);
    @(negedge clk);
    reg_we = we; reg_wdata = wd; chan_done = dn; chan_done_rep = rp;
    for (int i = 0; i < NCH; i++) begin
      exp_ab[i] = we && wd[7] && wd[i];
      if (we && !wd[7])            exp_arm[i] = wd[i];
      else if (we && wd[7] && wd[i]) exp_arm[i] = 1'b0;
      else if (dn[i] && !rp[i])     exp_arm[i] = 1'b0;
    end
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; chan_done = '0; chan_done_rep = '0;
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin exp_arm[i] = 0; exp_ab[i] = 0; end
    repeat (3) @(posedge clk);
    #1 compare("R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1 after release");

    step(1, 8'h15, '0, '0, "R3 load 10101");
    step(1, 8'h6A, '0, '0, "R3 R2 load 01010 pad ones");
    step(1, 8'h1F, '0, '0, "R3 load all");
    step(1, 8'h85, '0, '0, "R4 R5 abort ch0 ch2");
    step(0, 8'h00, '0, '0, "R5 pulse gone");
    step(1, 8'h80, '0, '0, "R4 R5 abort none selected");
    step(0, 8'h00, 5'b00010, 5'b00000, "R6 auto clear ch1");
    step(0, 8'h00, 5'b01000, 5'b01000, "R7 repetitive keeps ch3");
    step(0, 8'h00, 5'b00101, 5'b00000, "R6 R9 done on idle channels");
    step(1, 8'h1F, 5'b11111, 5'b00000, "R8 write wins over auto clear");
    step(1, 8'h83, 5'b11111, 5'b00100, "R8 abort plus completions");
    step(1, 8'h9F, '0, '0, "R4 R5 abort all");
    step(1, 8'hE0, '0, '0, "R9 R2 abort with no channels");
    step(1, 8'h0C, 5'b01100, 5'b01100, "R8 R7 load with repetitive");
    step(1, 8'h8C, '0, '0, "R5 back to back abort 1");
    step(1, 8'h8C, '0, '0, "R5 back to back abort 2");
    step(0, 8'h00, '0, '0, "R9 idle");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule